// File: doc/BRIEF.md
# Rollback-Aware Stream Data Verifier

This block sits on the receive side of a TCP offload path and checks the payload it delivers. Payload arrives as 32-bit beats with a valid strobe, a 4-bit byte enable, an end-of-packet marker and an 8-bit error code. Every accepted byte is counted in a 48-bit running count. When checking is switched on, each enabled byte is compared against a stream in which each 32-bit word holds its own word index, so byte position P carries byte (P mod 4) of the value floor(P/4).

Links can corrupt packets, and the offload engine then sends the same data again. The verifier handles this by committing its count only at the end of a clean packet. After a packet that ends with a nonzero error code, it reloads the count from the last committed value, so the retransmitted copy is counted and checked from the same stream position. Mismatches are held as pending until the packet ends and are only recorded if the packet turns out to be clean. A nonzero error code raises an interrupt flag and is latched until software acknowledges it. A transfer-clear pulse prepares the block for a new test. The whole block runs in the receive clock domain.

Top module: `rx_pattern_checker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `byte_count`, `fail_flag`, `fail_pos`, `fail_exp`, `fail_got`, `err_irq` and `err_code` are all zero.
- R2: A beat with `in_valid`=1 adds the number of set bits of `in_be` to `byte_count`, which shows the new value one cycle later. Cycles without `in_valid` leave `byte_count` unchanged.
- R3: At a beat with `in_valid`=1, `in_eop`=1 and `in_err`=0, the updated count becomes the committed count. At a beat with `in_valid`=1, `in_eop`=1 and a nonzero `in_err`, `byte_count` returns to the committed count on the next cycle.
- R4: Let P be `byte_count` before a beat. On lane k (bits 8k+7:8k), the expected byte is byte ((P+k) mod 4) of the 32-bit value floor((P+k)/4). Only lanes whose `in_be` bit is 1 are compared. A mismatch counts only if `check_en` is 1 on that beat.
- R5: The first mismatching beat of a packet is held as pending. At that packet's end-of-packet beat, if `in_err`=0 and no failure is recorded yet, `fail_flag` rises on the next cycle. At the same time `fail_pos` (P of that beat), `fail_exp` (the full 4-lane expected word) and `fail_got` (the received word) are captured. A packet that ends with a nonzero error code discards its pending mismatch.
- R6: Once `fail_flag` is 1, it and the captured record stay unchanged until a transfer clear.
- R7: `in_err` is sampled only on beats with `in_valid`=1 and `in_eop`=1. If it is nonzero while `err_irq` is 0, `err_irq` becomes 1 and `err_code` takes that code on the next cycle. Later errors do not change `err_code` while `err_irq` is 1.
- R8: A pulse on `err_ack` clears `err_irq` and `err_code` on the next cycle. A nonzero-error end-of-packet beat in the same cycle as `err_ack` is latched instead.
- R9: A pulse on `xfer_clr` zeroes `byte_count`, the committed count, any pending mismatch and the fail record on the next cycle. A beat in the same cycle adds no bytes and no mismatch. `err_irq` and `err_code` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| check_en | input | 1 | Enables pattern comparison |
| xfer_clr | input | 1 | One-cycle pulse: clear count and fail record |
| err_ack | input | 1 | One-cycle pulse: clear interrupt and latched code |
| in_valid | input | 1 | Beat valid |
| in_data | input | 32 | Payload word, lane 0 in bits 7:0 |
| in_be | input | 4 | Byte enable per lane |
| in_eop | input | 1 | Last beat of packet |
| in_err | input | 8 | Packet error code, meaningful at end-of-packet |
| byte_count | output | 48 | Running received byte count |
| fail_flag | output | 1 | Sticky verification failure |
| fail_pos | output | 48 | Byte position of first failing beat |
| fail_exp | output | 32 | Expected word at first failure |
| fail_got | output | 32 | Received word at first failure |
| err_irq | output | 1 | Error interrupt flag |
| err_code | output | 8 | First latched nonzero error code |

## Verification
Every result of this block is due exactly one clock after the beat or pulse that causes it. This holds for the count, the reload, the committed fail record at end-of-packet and the interrupt latch. A pending mismatch becomes visible only in the cycle after the end-of-packet beat of its packet, never earlier. The bench drives each cycle on the falling edge and advances its behavioural model with the same inputs. It then compares every output against the model on the next falling edge, so each output is sampled after the one register stage that produces it.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
    localparam int unsigned CNT_W  = 48;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ERR_W  = 8;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned OFS_W  = $clog2(LANES);
    localparam int unsigned NB_W   = $clog2(LANES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  pos;
        logic [DATA_W-1:0] expw;
        logic [DATA_W-1:0] got;
    } fail_rec_t;

    function automatic logic [NB_W-1:0] lane_count(input logic [LANES-1:0] be);
        logic [NB_W-1:0] n;
        n = '0;
        for (int k = 0; k < LANES; k++) n = n + NB_W'(be[k]);
        return n;
    endfunction

    // lane k carries stream byte base+k of the self-indexed word stream
    function automatic logic [DATA_W-1:0] pattern_word(input logic [CNT_W-1:0] base);
        logic [DATA_W-1:0] w;
        logic [CNT_W-1:0]  p;
        logic [DATA_W-1:0] v;
        w = '0;
        for (int k = 0; k < LANES; k++) begin
            p = base + CNT_W'(k);
            v = p[OFS_W +: DATA_W];
            w[8*k +: 8] = v[8*p[OFS_W-1:0] +: 8];
        end
        return w;
    endfunction
endpackage

// File: rtl/rxchk_count.sv
module rxchk_count
    import rxchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             valid,
    input  logic [LANES-1:0] be,
    input  logic             eop,
    input  logic             bad_pkt,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] good;
    logic [CNT_W-1:0] nxt;

    assign nxt = cnt + CNT_W'(lane_count(be));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            good <= '0;
        end else if (valid) begin
            if (eop && bad_pkt) begin
                cnt <= good;
            end else begin
                cnt <= nxt;
                if (eop) good <= nxt;
            end
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !clr) |=> $stable(cnt));
    // R3
    rollback_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && eop && bad_pkt && !clr) |=> (cnt == $past(good)));
    // R3
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && eop && !bad_pkt && !clr) |=> (good == cnt));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && good == '0));
endmodule

// File: rtl/rxchk_compare.sv
module rxchk_compare
    import rxchk_pkg::*;
(
    input  logic              en,
    input  logic              valid,
    input  logic [CNT_W-1:0]  pos,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] expw,
    output logic              mism
);
    logic [LANES-1:0] lane_bad;

    assign expw = pattern_word(pos);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_bad[k] = be[k] && (data[8*k +: 8] != expw[8*k +: 8]);
    end

    assign mism = valid && en && (|lane_bad);
endmodule

// File: rtl/rxchk_failrec.sv
module rxchk_failrec
    import rxchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      valid,
    input  logic      eop,
    input  logic      bad_pkt,
    input  logic      mism,
    input  fail_rec_t cur,
    output logic      fail,
    output fail_rec_t rec
);
    logic      pend;
    fail_rec_t prec;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= 1'b0;
            prec <= '0;
            fail <= 1'b0;
            rec  <= '0;
        end else if (valid) begin
            if (eop) begin
                pend <= 1'b0;
                if (!bad_pkt && !fail && (pend || mism)) begin
                    fail <= 1'b1;
                    rec  <= pend ? prec : cur;
                end
            end else if (mism && !pend) begin
                pend <= 1'b1;
                prec <= cur;
            end
        end
    end

    // R6
    sticky_rec_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> (fail && $stable(rec)));
    // R5
    errored_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && eop && bad_pkt && !fail && !clr) |=> !fail);
    // R5
    mid_packet_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !eop && !fail && !clr) |=> !fail);
endmodule

// File: rtl/rxchk_errlatch.sv
module rxchk_errlatch
    import rxchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic             valid,
    input  logic             eop,
    input  logic [ERR_W-1:0] err,
    output logic             irq,
    output logic [ERR_W-1:0] code
);
    logic take;

    assign take = valid && eop && (err != '0) && (!irq || ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq  <= 1'b0;
            code <= '0;
        end else if (take) begin
            irq  <= 1'b1;
            code <= err;
        end else if (ack) begin
            irq  <= 1'b0;
            code <= '0;
        end
    end

    // R7
    hold_first_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> (irq && $stable(code)));
    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !(valid && eop && err != '0)) |=> (!irq && code == '0));
    // R7
    no_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(valid && eop)) |=> !irq);
endmodule

// File: rtl/rx_pattern_checker.sv
module rx_pattern_checker
    import rxchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              check_en,
    input  logic              xfer_clr,
    input  logic              err_ack,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_be,
    input  logic              in_eop,
    input  logic [ERR_W-1:0]  in_err,
    output logic [CNT_W-1:0]  byte_count,
    output logic              fail_flag,
    output logic [CNT_W-1:0]  fail_pos,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got,
    output logic              err_irq,
    output logic [ERR_W-1:0]  err_code
);
    logic              bad_pkt;
    logic [DATA_W-1:0] expw;
    logic              mism;
    fail_rec_t         cur_rec;
    fail_rec_t         rec;

    assign bad_pkt = (in_err != '0);

    rxchk_count u_count (
        .clk     (clk),
        .rst     (rst),
        .clr     (xfer_clr),
        .valid   (in_valid),
        .be      (in_be),
        .eop     (in_eop),
        .bad_pkt (bad_pkt),
        .cnt     (byte_count)
    );

    rxchk_compare u_compare (
        .en    (check_en),
        .valid (in_valid),
        .pos   (byte_count),
        .data  (in_data),
        .be    (in_be),
        .expw  (expw),
        .mism  (mism)
    );

    assign cur_rec = '{pos: byte_count, expw: expw, got: in_data};

    rxchk_failrec u_failrec (
        .clk     (clk),
        .rst     (rst),
        .clr     (xfer_clr),
        .valid   (in_valid),
        .eop     (in_eop),
        .bad_pkt (bad_pkt),
        .mism    (mism),
        .cur     (cur_rec),
        .fail    (fail_flag),
        .rec     (rec)
    );

    assign fail_pos = rec.pos;
    assign fail_exp = rec.expw;
    assign fail_got = rec.got;

    rxchk_errlatch u_errlatch (
        .clk   (clk),
        .rst   (rst),
        .ack   (err_ack),
        .valid (in_valid),
        .eop   (in_eop),
        .err   (in_err),
        .irq   (err_irq),
        .code  (err_code)
    );

    // R4
    disabled_check_chk: assert property (@(posedge clk) disable iff (rst)
        !check_en |-> !mism);
    // R4
    lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_be == '0) |-> !mism);
endmodule

// File: tb/test_rx_pattern_checker.sv
module test_rx_pattern_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        check_en = 1'b0;
    logic        xfer_clr = 1'b0;
    logic        err_ack = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic        in_eop = 1'b0;
    logic [7:0]  in_err = '0;
    logic [47:0] byte_count;
    logic        fail_flag;
    logic [47:0] fail_pos;
    logic [31:0] fail_exp;
    logic [31:0] fail_got;
    logic        err_irq;
    logic [7:0]  err_code;

    always #2.5 clk = ~clk;

    rx_pattern_checker i_rx_pattern_checker (
        .clk(clk), .rst(rst), .check_en(check_en), .xfer_clr(xfer_clr),
        .err_ack(err_ack), .in_valid(in_valid), .in_data(in_data),
        .in_be(in_be), .in_eop(in_eop), .in_err(in_err),
        .byte_count(byte_count), .fail_flag(fail_flag), .fail_pos(fail_pos),
        .fail_exp(fail_exp), .fail_got(fail_got), .err_irq(err_irq),
        .err_code(err_code)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";

    // behavioural reference state
    longint unsigned m_cnt = 0, m_good = 0;
    bit              m_pend = 0, m_fail = 0, m_irq = 0;
    longint unsigned m_ppos = 0, m_fpos = 0;
    logic [31:0]     m_pexp = 0, m_pgot = 0, m_fexp = 0, m_fgot = 0;
    logic [7:0]      m_code = 0;

    function automatic logic [7:0] stream_byte(longint unsigned q);
        logic [31:0] w;
        w = 32'(q / 4);
        return w[8*(q % 4) +: 8];
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("byte_count", 64'(byte_count), 64'(m_cnt));
        chk("fail_flag", 64'(fail_flag), 64'(m_fail));
        chk("fail_pos", 64'(fail_pos), 64'(m_fpos));
        chk("fail_exp", 64'(fail_exp), 64'(m_fexp));
        chk("fail_got", 64'(fail_got), 64'(m_fgot));
        chk("err_irq", 64'(err_irq), 64'(m_irq));
        chk("err_code", 64'(err_code), 64'(m_code));
    endtask

    task automatic model_step();
        int          nb;
        bit          mis;
        logic [31:0] ew;
        nb = 0; mis = 0;
        for (int k = 0; k < 4; k++) begin
            ew[8*k +: 8] = stream_byte(m_cnt + longint'(k));
            if (in_be[k]) begin
                nb++;
                if (in_data[8*k +: 8] != ew[8*k +: 8]) mis = 1;
            end
        end
        mis = mis && in_valid && check_en;
        if (in_valid && in_eop && in_err != 0 && (!m_irq || err_ack)) begin
            m_irq = 1; m_code = in_err;
        end else if (err_ack) begin
            m_irq = 0; m_code = 0;
        end
        if (xfer_clr) begin
            m_cnt = 0; m_good = 0; m_pend = 0; m_fail = 0;
            m_fpos = 0; m_fexp = 0; m_fgot = 0;
        end else if (in_valid) begin
            if (in_eop) begin
                if (in_err == 0) begin
                    if (!m_fail && (m_pend || mis)) begin
                        m_fail = 1;
                        if (m_pend) begin
                            m_fpos = m_ppos; m_fexp = m_pexp; m_fgot = m_pgot;
                        end else begin
                            m_fpos = m_cnt; m_fexp = ew; m_fgot = in_data;
                        end
                    end
                    m_cnt = m_cnt + longint'(nb);
                    m_good = m_cnt;
                end else begin
                    m_cnt = m_good;
                end
                m_pend = 0;
            end else begin
                if (mis && !m_pend) begin
                    m_pend = 1; m_ppos = m_cnt; m_pexp = ew; m_pgot = in_data;
                end
                m_cnt = m_cnt + longint'(nb);
            end
        end
    endtask

    // called at a falling edge; inputs hold for one cycle
    task automatic cyc(bit v, logic [31:0] d, logic [3:0] be, bit eop,
                       logic [7:0] err, bit clr, bit ack);
        in_valid = v; in_data = d; in_be = be; in_eop = eop; in_err = err;
        xfer_clr = clr; err_ack = ack;
        model_step();
        @(negedge clk);
        compare_all();
        in_valid = 0; in_eop = 0; in_be = 0; in_err = 0; xfer_clr = 0; err_ack = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 32'h0, 4'h0, 0, 8'h0, 0, 0);
    endtask

    // bad: packet byte index to corrupt, -1 for none; disabled lanes carry junk
    task automatic send_pkt(longint unsigned start, int len, logic [7:0] err,
                            int bad, bit ack_eop);
        for (int i = 0; i < len; i += 4) begin
            int          n;
            logic [31:0] d;
            logic [3:0]  be;
            bit          last;
            n = (len - i < 4) ? len - i : 4;
            be = 4'((1 << n) - 1);
            last = (i + 4 >= len);
            for (int k = 0; k < 4; k++) begin
                if (k < n) begin
                    d[8*k +: 8] = stream_byte(start + longint'(i + k));
                    if (i + k == bad) d[8*k +: 8] = d[8*k +: 8] ^ 8'h5A;
                end else begin
                    d[8*k +: 8] = 8'hEE;
                end
            end
            cyc(1, d, be, last, last ? err : 8'h0, 0, last && ack_eop);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        compare_all();
        rst = 0;
        idle(1);

        req = "R2"; check_en = 1;
        send_pkt(0, 7, 8'h0, -1, 0);
        idle(2);
        send_pkt(7, 5, 8'h0, -1, 0);
        send_pkt(12, 12, 8'h0, -1, 0);
        chk("count after three packets", 64'(byte_count), 64'd24);

        req = "R3";
        send_pkt(24, 6, 8'h21, 2, 0);
        chk("rollback count", 64'(byte_count), 64'd24);
        send_pkt(24, 6, 8'h0, -1, 0);
        chk("retransmit count", 64'(byte_count), 64'd30);

        req = "R7";
        send_pkt(30, 3, 8'h33, -1, 0);
        chk("first code kept", 64'(err_code), 64'h21);
        send_pkt(30, 3, 8'h0, -1, 0);

        req = "R8";
        cyc(0, 0, 0, 0, 8'h0, 0, 1);
        chk("ack clears irq", 64'(err_irq), 64'd0);
        send_pkt(33, 4, 8'h55, -1, 0);
        send_pkt(33, 4, 8'h44, -1, 1);
        chk("code latched under ack", 64'(err_code), 64'h44);
        cyc(0, 0, 0, 0, 8'h0, 0, 1);
        send_pkt(33, 4, 8'h0, -1, 0);

        req = "R4";
        check_en = 0;
        send_pkt(37, 5, 8'h0, 1, 0);
        check_en = 1;
        send_pkt(42, 7, 8'h0, -1, 0);
        chk("no fail from masked lanes", 64'(fail_flag), 64'd0);

        req = "R5";
        send_pkt(49, 10, 8'h0, 5, 0);
        chk("fail recorded", 64'(fail_flag), 64'd1);

        req = "R6";
        send_pkt(59, 8, 8'h0, 0, 0);
        idle(2);

        req = "R9";
        cyc(1, 32'hDEADBEEF, 4'hF, 0, 8'h0, 1, 0);
        chk("clear count", 64'(byte_count), 64'd0);
        send_pkt(0, 6, 8'h0, 5, 0);
        chk("fail after clear", 64'(fail_pos), 64'd4);
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog actual hung expected finished", req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule